// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

The unit works on one 32-bit word per cycle and does one of two things with a contiguous bit field. To extract, it pulls the field out of a source word and returns it right-aligned, with zeros above it. To insert, it writes a right-aligned value into the field of a destination word and leaves every other destination bit alone. The field is given by the position of its most significant bit and its width in bits.

Extraction uses two logical shifts. A left shift moves the field's top bit to bit 31. A zero-filling right shift by the word width minus the field width then brings the field down. Insertion happens in three steps. A full-width AND mask clears the field. The value, cut to the field width, is shifted up to the field's low bit. An OR then merges it into the word. A request whose field would run below bit 0, or whose width is zero, is rejected with an error flag and a zero result. The result is registered, so it appears one clock after the request.

Top module: `bfx_unit`

## Requirements
- R1: While `rst_ni` is low, and up to the first rising clock edge after it goes high, `data_o` is 0 and `err_o` is 0.
- R2: Every output is the registered result of the inputs sampled at the previous rising edge of `clk_i`.
- R3: With `mode_i`=0 (extract) and a legal field, `data_o` bit i equals `word_i` bit (lo+i) for i below the width, where lo = `top_i` - `width_i` + 1.
- R4: In extract mode, the bits of `data_o` at and above position `width_i` are zero.
- R5: With `mode_i`=1 (insert) and a legal field, the bits of `data_o` outside top..lo equal the same bits of `word_i`, including bits 16 to 31.
- R6: In insert mode, bits top..lo of `data_o` hold bits `width_i`-1..0 of `field_i`.
- R7: In insert mode, the bits of `field_i` at and above position `width_i` have no effect on `data_o`.
- R8: When `width_i` is 0 or greater than `top_i`+1, `err_o` is 1 and `data_o` is 0. Otherwise `err_o` is 0.
- R9: With `width_i`=32 and `top_i`=31, extract returns `word_i` unchanged and insert returns `field_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = extract, 1 = insert |
| top_i | input | 5 | Bit position of the field's most significant bit |
| width_i | input | 6 | Field width in bits, legal range 1..32 |
| word_i | input | 32 | Source word (extract) or destination word (insert) |
| field_i | input | 32 | Right-aligned value to insert; unused in extract mode |
| data_o | output | 32 | Registered result |
| err_o | output | 1 | Registered error flag for an illegal field |

## Verification
The properties compare each output with the inputs sampled one edge earlier. They assume every input is driven to a known value on every edge after reset, and that `width_i` may take any 6-bit value, including the illegal ones. The stimulus changes the inputs only at falling edges. It covers every pair of top bit and width in both modes, with random words and random upper value bits. It also sends widths of 0 and 33, so the error rule and the legal space are both exercised.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  typedef enum logic {
    BFX_EXTRACT = 1'b0,
    BFX_INSERT  = 1'b1
  } bfx_mode_e;
endpackage

// File: rtl/bfx_range.sv
module bfx_range #(
  parameter int DATA_W = 32,
  localparam int POS_W = $clog2(DATA_W),
  localparam int WID_W = POS_W + 1
) (
  input  logic [POS_W-1:0] top_i,
  input  logic [WID_W-1:0] width_i,
  output logic             valid_o,
  output logic [POS_W-1:0] low_o
);
  logic [WID_W:0] span;
  logic [WID_W:0] low_ext;

  assign span    = {2'b00, top_i} + 1'b1;
  assign valid_o = (width_i != '0) && ({1'b0, width_i} <= span);
  assign low_ext = span - {1'b0, width_i};
  assign low_o   = low_ext[POS_W-1:0];
endmodule

// File: rtl/bfx_extract.sv
module bfx_extract #(
  parameter int DATA_W = 32,
  localparam int POS_W = $clog2(DATA_W),
  localparam int WID_W = POS_W + 1
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [POS_W-1:0]  top_i,
  input  logic [WID_W-1:0]  width_i,
  output logic [DATA_W-1:0] res_o
);
  logic [WID_W-1:0]  shl_amt;
  logic [WID_W-1:0]  shr_amt;
  logic [DATA_W-1:0] aligned_hi;

  // top bit to MSB, then zero-fill down to bit 0
  assign shl_amt    = WID_W'(DATA_W - 1) - {1'b0, top_i};
  assign shr_amt    = WID_W'(DATA_W) - width_i;
  assign aligned_hi = src_i << shl_amt;
  assign res_o      = aligned_hi >> shr_amt;
endmodule

// File: rtl/bfx_insert.sv
module bfx_insert #(
  parameter int DATA_W = 32,
  localparam int POS_W = $clog2(DATA_W),
  localparam int WID_W = POS_W + 1
) (
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic [POS_W-1:0]  low_i,
  input  logic [WID_W-1:0]  width_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] low_ones;
  logic [DATA_W-1:0] clr_mask;
  logic [DATA_W-1:0] cleared;
  logic [DATA_W-1:0] placed;

  // width == DATA_W shifts everything out -> all ones
  assign low_ones = ~({DATA_W{1'b1}} << width_i);
  assign clr_mask = ~(low_ones << low_i);
  assign cleared  = dst_i & clr_mask;
  assign placed   = (val_i & low_ones) << low_i;
  assign res_o    = cleared | placed;
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int POS_W = $clog2(DATA_W),
  localparam int WID_W = POS_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic [POS_W-1:0]  top_i,
  input  logic [WID_W-1:0]  width_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [DATA_W-1:0] field_i,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o
);
  logic              valid;
  logic [POS_W-1:0]  low;
  logic [DATA_W-1:0] ext_res;
  logic [DATA_W-1:0] ins_res;
  logic [DATA_W-1:0] data_d;
  bfx_mode_e         mode;

  assign mode = bfx_mode_e'(mode_i);

  bfx_range #(.DATA_W(DATA_W)) i_range (
    .top_i   (top_i),
    .width_i (width_i),
    .valid_o (valid),
    .low_o   (low)
  );

  bfx_extract #(.DATA_W(DATA_W)) i_extract (
    .src_i   (word_i),
    .top_i   (top_i),
    .width_i (width_i),
    .res_o   (ext_res)
  );

  bfx_insert #(.DATA_W(DATA_W)) i_insert (
    .dst_i   (word_i),
    .val_i   (field_i),
    .low_i   (low),
    .width_i (width_i),
    .res_o   (ins_res)
  );

  always_comb begin
    if (!valid)                   data_d = '0;
    else if (mode == BFX_INSERT)  data_d = ins_res;
    else                          data_d = ext_res;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      err_o  <= 1'b0;
    end else begin
      data_o <= data_d;
      err_o  <= ~valid;
    end
  end
endmodule

// File: rtl/bfx_unit_chk.sv
module bfx_unit_chk #(
  parameter int DATA_W = 32,
  localparam int POS_W = $clog2(DATA_W),
  localparam int WID_W = POS_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_i,
  input logic [POS_W-1:0]  top_i,
  input logic [WID_W-1:0]  width_i,
  input logic [DATA_W-1:0] word_i,
  input logic [DATA_W-1:0] field_i,
  input logic [DATA_W-1:0] data_o,
  input logic              err_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  function automatic logic legal(logic [POS_W-1:0] t, logic [WID_W-1:0] w);
    return (w != 0) && (int'(w) <= int'(t) + 1);
  endfunction

  function automatic logic [DATA_W-1:0] ones(logic [WID_W-1:0] w);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++) if (i < int'(w)) m[i] = 1'b1;
    return m;
  endfunction

  function automatic int low_of(logic [POS_W-1:0] t, logic [WID_W-1:0] w);
    return int'(t) - int'(w) + 1;
  endfunction

  AST_RESET_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (data_o == '0 && !err_o)); // R1

  AST_ERR_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && !legal($past(top_i), $past(width_i)) |-> (err_o && data_o == '0)); // R8

  AST_NO_FALSE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && legal($past(top_i), $past(width_i)) |-> !err_o); // R8

  AST_EXT_ZERO_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && !$past(mode_i) |-> (data_o & ~ones($past(width_i))) == '0); // R4

  AST_INS_KEEP_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(mode_i) && legal($past(top_i), $past(width_i)) |->
    ((data_o ^ $past(word_i)) &
     ~(ones($past(width_i)) << low_of($past(top_i), $past(width_i)))) == '0); // R5

  AST_INS_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(mode_i) && legal($past(top_i), $past(width_i)) |->
    ((data_o >> low_of($past(top_i), $past(width_i))) & ones($past(width_i))) ==
    ($past(field_i) & ones($past(width_i)))); // R6
endmodule

bind bfx_unit bfx_unit_chk #(.DATA_W(DATA_W)) i_bfx_unit_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mode_i  (mode_i),
  .top_i   (top_i),
  .width_i (width_i),
  .word_i  (word_i),
  .field_i (field_i),
  .data_o  (data_o),
  .err_o   (err_o)
);

// File: tb/test_bfx_unit.sv
module test_bfx_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_i = 1'b0;
  logic [4:0]  top_i = '0;
  logic [5:0]  width_i = '0;
  logic [31:0] word_i = '0;
  logic [31:0] field_i = '0;
  logic [31:0] data_o;
  logic        err_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  bfx_unit i_bfx_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .top_i(top_i),
    .width_i(width_i), .word_i(word_i), .field_i(field_i),
    .data_o(data_o), .err_o(err_o)
  );

  task automatic check(string tag, logic [31:0] exp_d, logic exp_e);
    n_checks++;
    if (data_o !== exp_d || err_o !== exp_e) begin
      n_errors++;
      $display("FAIL %s: data=%h err=%b expected data=%h err=%b", tag, data_o, err_o, exp_d, exp_e);
    end
  endtask

  // apply at falling edge, sample one full cycle later (after the capturing edge)
  task automatic run(logic m, int t, int w, logic [31:0] wd, logic [31:0] fv);
    mode_i = m; top_i = 5'(t); width_i = 6'(w); word_i = wd; field_i = fv;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  function automatic logic [32:0] model(logic m, int t, int w, logic [31:0] wd, logic [31:0] fv);
    logic [31:0] r;
    int lo;
    lo = t - w + 1;
    if (w == 0 || lo < 0) return {1'b1, 32'h0};
    r = m ? wd : 32'h0;
    for (int i = 0; i < w; i++) begin
      if (m) r[lo+i] = fv[i];
      else   r[i] = wd[lo+i];
    end
    return {1'b0, r};
  endfunction

  task automatic run_chk(string tag, logic m, int t, int w, logic [31:0] wd, logic [31:0] fv);
    logic [32:0] e;
    e = model(m, t, w, wd, fv);
    run(m, t, w, wd, fv);
    check(tag, e[31:0], e[32]);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: data=%h err=%b expected completion", data_o, err_o);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    mode_i = 1'b0; top_i = 5'd9; width_i = 6'd8; word_i = 32'hFFFF_FFFF; field_i = '0;
    repeat (3) @(negedge clk_i);
    check("R1 in reset", 32'h0, 1'b0);
    rst_ni = 1'b1;
    check("R1 after release", 32'h0, 1'b0);
    // R2: output follows the previous edge's inputs
    run(1'b0, 9, 8, 32'h0000_03FC, 32'h0);
    check("R2 latency", 32'h0000_00FF, 1'b0);
    run_chk("R3 extract 9..2", 1'b0, 9, 8, 32'h1234_5678, 32'h0);
    run_chk("R5 insert keeps upper half", 1'b1, 9, 8, 32'hFFFF_FFFF, 32'h0);
    check("R5 explicit mask", 32'hFFFF_FC03, 1'b0);
    run_chk("R7 upper value bits ignored", 1'b1, 9, 8, 32'h0, 32'hFFFF_FFFF);
    check("R7 explicit", 32'h0000_03FC, 1'b0);
    run_chk("R9 whole word extract", 1'b0, 31, 32, 32'hDEAD_BEEF, 32'h0);
    check("R9 explicit extract", 32'hDEAD_BEEF, 1'b0);
    run_chk("R9 whole word insert", 1'b1, 31, 32, 32'h1111_1111, 32'hCAFE_F00D);
    check("R9 explicit insert", 32'hCAFE_F00D, 1'b0);
    run_chk("R8 width zero", 1'b0, 31, 0, 32'hFFFF_FFFF, 32'h0);
    run_chk("R8 width 33", 1'b1, 31, 33, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_chk("R8 width past bit 0", 1'b1, 3, 5, 32'hFFFF_FFFF, 32'h1F);
    for (int m = 0; m < 2; m++) begin
      for (int t = 0; t < 32; t++) begin
        for (int w = 1; w <= 32; w++) begin
          run_chk(m ? ((w > t + 1) ? "R8 sweep" : "R5 R6 R7 sweep insert")
                    : ((w > t + 1) ? "R8 sweep" : "R3 R4 sweep extract"),
                  logic'(m), t, w, $urandom(), $urandom());
        end
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule